// File: doc/BRIEF.md
# Barrel-Thread Program Counter Ring

This block sequences the instruction fetch of a processor whose pipeline is shared by a fixed set of hardware threads, one thread per pipeline stage. It holds one program counter per thread and hands the issue slot to the next thread on every clock in a fixed circular order. The program counter of the thread that owns the current slot is presented as the fetch address into the program space, which all threads share.

In the same slot, the surrounding pipeline tells the ring how the issuing thread's flow resolves. The options are a plain step, a conditional skip over one instruction, or a jump to a given target. The skip decision is a value computed in that slot, because the machine keeps no condition flags. Each thread also has its own interrupt request and enable. A request is honoured only in that thread's own slot. It turns the slot into a single stall, reports the address where the thread would have continued as the return address, and loads the thread's fixed entry vector. A slot that a thread does not use is never given to another thread.

Top module: `pcr_ring`

## Requirements
- R1: While reset (active-low) is held and right after it is released, the issuing thread is 0 and each thread's PC holds its own vector, VEC_BASE + thread*VEC_STRIDE (defaults 0x0100 and 4).
- R2: The issuing thread number advances by one on every clock and wraps from NTHR-1 to 0.
- R3: The fetch address always equals the current PC of the issuing thread.
- R4: With no jump, skip or interrupt in its slot, the issuing thread's PC is increased by 1 at its next turn.
- R5: When the skip input is high in a thread's slot and there is no jump, that thread's PC is increased by 2.
- R6: When the jump input is high in a thread's slot, that thread's PC becomes the jump target, and any skip in the same slot is ignored.
- R7: When both irq_i and irq_en_i are high for the issuing thread, stall_o is high in that slot, ret_addr_o shows the address the flow would have reached, and the thread's next PC is its vector.
- R8: An interrupt request whose enable bit is low, or whose thread is not issuing, does not raise stall_o and does not change any PC.
- R9: When a jump and an interrupt are taken in the same slot, ret_addr_o equals the jump target.
- R10: A slot's update changes only the issuing thread's PC. All other threads keep their PCs.
- R11: PC arithmetic wraps modulo 2^ADDR_W. For example, 0xFFFF plus 1 gives 0x0000 and 0xFFFF plus 2 gives 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| irq_i | input | NTHR | Interrupt request, one bit per thread |
| irq_en_i | input | NTHR | Interrupt enable, one bit per thread |
| jmp_i | input | 1 | The issuing thread jumps |
| jmp_tgt_i | input | ADDR_W | Jump target |
| skip_i | input | 1 | Skip condition holds for the issuing thread |
| fetch_addr_o | output | ADDR_W | Fetch address (PC of the issuing thread) |
| fetch_thr_o | output | $clog2(NTHR) | Issuing thread number |
| stall_o | output | 1 | Slot is consumed by interrupt entry |
| ret_addr_o | output | ADDR_W | Return address, meaningful while stall_o is high |

## Verification
Flow resolution and interrupt entry can land in the same slot. A jump or a skip may arrive in the very slot where that thread's request is taken. The bench provokes this with directed cases, a jump plus an interrupt and a skip plus an interrupt, and also with long random runs in which the requests, enables, jumps and skips are all drawn independently. A behavioural model judges each case. It requires the return address to be the flow result: the jump target, or the PC plus 2 after a skip. It also requires the PC at the thread's next turn to be its vector, with the flow result dropped.

// File: rtl/pcr_pkg.sv
// Package: shared types for the program counter ring.
// Assumes: nothing beyond IEEE 1800-2017.
package pcr_pkg;

    // Kind of update applied to the issuing thread's PC
    typedef enum logic [1:0] {
        FLOW_STEP = 2'd0,
        FLOW_SKIP = 2'd1,
        FLOW_JUMP = 2'd2,
        FLOW_TRAP = 2'd3
    } flow_kind_e;

endpackage

// File: rtl/pcr_slot_ctr.sv
// Module: pcr_slot_ctr
// Rotates the issue slot across NTHR threads, one step per clock.
// Assumes: NTHR >= 2; synchronous active-low reset returns to thread 0.
module pcr_slot_ctr #(
    parameter int NTHR = 8,
    localparam int TW  = $clog2(NTHR)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    output logic [TW-1:0] slot_o,
    output logic [NTHR-1:0] slot_oh_o
);

    localparam logic [TW-1:0] LAST = TW'(NTHR - 1);

    logic [TW-1:0] slot_q;

    // Advance the slot, wrapping after the last thread
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            slot_q <= '0;
        else if (slot_q == LAST)
            slot_q <= '0;
        else
            slot_q <= slot_q + TW'(1);
    end

    // One-hot view of the issuing thread
    for (genvar g = 0; g < NTHR; g++) begin : g_oh
        assign slot_oh_o[g] = (slot_q == TW'(g));
    end

    assign slot_o = slot_q;

endmodule

// File: rtl/pcr_next_pc.sv
// Module: pcr_next_pc
// Resolves the issuing thread's next PC from step, skip, jump and trap.
// Assumes: all inputs belong to the same slot; jump outranks skip,
// and a trap replaces the flow result, which is kept as return address.
module pcr_next_pc
    import pcr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur_pc_i,
    input  logic              jmp_i,
    input  logic [ADDR_W-1:0] jmp_tgt_i,
    input  logic              skip_i,
    input  logic              trap_i,
    input  logic [ADDR_W-1:0] vec_i,
    output logic [ADDR_W-1:0] flow_pc_o,
    output logic [ADDR_W-1:0] new_pc_o,
    output flow_kind_e        kind_o
);

    // Classify the update for this slot
    always_comb begin
        if (trap_i)
            kind_o = FLOW_TRAP;
        else if (jmp_i)
            kind_o = FLOW_JUMP;
        else if (skip_i)
            kind_o = FLOW_SKIP;
        else
            kind_o = FLOW_STEP;
    end

    // Flow address ignoring the trap (modulo 2^ADDR_W)
    always_comb begin
        if (jmp_i)
            flow_pc_o = jmp_tgt_i;
        else if (skip_i)
            flow_pc_o = cur_pc_i + ADDR_W'(2);
        else
            flow_pc_o = cur_pc_i + ADDR_W'(1);
    end

    // Final PC written back for the issuing thread
    always_comb begin
        new_pc_o = (kind_o == FLOW_TRAP) ? vec_i : flow_pc_o;
    end

endmodule

// File: rtl/pcr_pc_bank.sv
// Module: pcr_pc_bank
// Holds one PC per thread; writes only the selected thread, reads by slot.
// Assumes: wr_oh_i is one-hot; each PC resets to its own vector.
module pcr_pc_bank #(
    parameter int               NTHR       = 8,
    parameter int               ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE  = 16'h0100,
    parameter int               VEC_STRIDE = 4,
    localparam int              TW         = $clog2(NTHR)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NTHR-1:0]   wr_oh_i,
    input  logic [ADDR_W-1:0] wr_pc_i,
    input  logic [TW-1:0]     rd_sel_i,
    output logic [ADDR_W-1:0] rd_pc_o
);

    logic [ADDR_W-1:0] pc_q [NTHR];

    for (genvar g = 0; g < NTHR; g++) begin : g_pc
        localparam logic [ADDR_W-1:0] RST_PC = VEC_BASE + ADDR_W'(VEC_STRIDE * g);

        // Per-thread PC register, loaded only in its own slot
        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                pc_q[g] <= RST_PC;
            else if (wr_oh_i[g])
                pc_q[g] <= wr_pc_i;
        end
    end

    // Read port for the issuing thread
    always_comb begin
        rd_pc_o = pc_q[rd_sel_i];
    end

endmodule

// File: rtl/pcr_ring.sv
// Module: pcr_ring (top)
// Barrel-thread PC ring: rotates issue across threads, presents the
// fetch address and applies step/skip/jump/interrupt updates.
// Assumes: flow inputs describe the issuing thread in the same slot;
// an interrupt is taken only in its own thread's slot when enabled.
module pcr_ring
    import pcr_pkg::*;
#(
    parameter int               NTHR       = 8,
    parameter int               ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE  = 16'h0100,
    parameter int               VEC_STRIDE = 4,
    localparam int              TW         = $clog2(NTHR)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NTHR-1:0]   irq_i,
    input  logic [NTHR-1:0]   irq_en_i,
    input  logic              jmp_i,
    input  logic [ADDR_W-1:0] jmp_tgt_i,
    input  logic              skip_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic [TW-1:0]     fetch_thr_o,
    output logic              stall_o,
    output logic [ADDR_W-1:0] ret_addr_o
);

    logic [TW-1:0]     slot;
    logic [NTHR-1:0]   slot_oh;
    logic [ADDR_W-1:0] cur_pc;
    logic [ADDR_W-1:0] flow_pc;
    logic [ADDR_W-1:0] new_pc;
    logic [ADDR_W-1:0] vec;
    logic              trap;
    flow_kind_e        kind;

    pcr_slot_ctr #(.NTHR(NTHR)) u_slot (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .slot_o    (slot),
        .slot_oh_o (slot_oh)
    );

    // Interrupt taken only for the issuing thread when enabled
    always_comb begin
        trap = |(irq_i & irq_en_i & slot_oh);
    end

    // Entry vector of the issuing thread
    always_comb begin
        vec = VEC_BASE + ADDR_W'(VEC_STRIDE) * ADDR_W'(slot);
    end

    pcr_next_pc #(.ADDR_W(ADDR_W)) u_next (
        .cur_pc_i  (cur_pc),
        .jmp_i     (jmp_i),
        .jmp_tgt_i (jmp_tgt_i),
        .skip_i    (skip_i),
        .trap_i    (trap),
        .vec_i     (vec),
        .flow_pc_o (flow_pc),
        .new_pc_o  (new_pc),
        .kind_o    (kind)
    );

    pcr_pc_bank #(
        .NTHR       (NTHR),
        .ADDR_W     (ADDR_W),
        .VEC_BASE   (VEC_BASE),
        .VEC_STRIDE (VEC_STRIDE)
    ) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_oh_i  (slot_oh),
        .wr_pc_i  (new_pc),
        .rd_sel_i (slot),
        .rd_pc_o  (cur_pc)
    );

    // Drive outputs of the slot
    always_comb begin
        fetch_addr_o = cur_pc;
        fetch_thr_o  = slot;
        stall_o      = (kind == FLOW_TRAP);
        ret_addr_o   = flow_pc;
    end

endmodule

// File: rtl/pcr_ring_chk.sv
// Module: pcr_ring_chk
// Port-level assertions for pcr_ring, bound into every instance.
// Assumes: same parameters as the bound instance.
module pcr_ring_chk #(
    parameter int               NTHR       = 8,
    parameter int               ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE  = 16'h0100,
    parameter int               VEC_STRIDE = 4,
    localparam int              TW         = $clog2(NTHR)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NTHR-1:0]   irq_i,
    input logic [NTHR-1:0]   irq_en_i,
    input logic              jmp_i,
    input logic [ADDR_W-1:0] jmp_tgt_i,
    input logic              skip_i,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic [TW-1:0]     fetch_thr_o,
    input logic              stall_o,
    input logic [ADDR_W-1:0] ret_addr_o
);

    logic            run_q;
    logic [NTHR-1:0] want_vec_q;

    // Marks cycles at least one clock past reset release
    always_ff @(posedge clk_i) begin
        run_q <= rst_ni;
    end

    // Threads whose next fetch must be their vector
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            want_vec_q <= '1;
        else
            want_vec_q[fetch_thr_o] <= stall_o;
    end

    p_rotate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q |-> fetch_thr_o == (($past(fetch_thr_o) == TW'(NTHR - 1)) ? '0 : $past(fetch_thr_o) + TW'(1)))
        else $error("rotation broken");

    p_vec_fetch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        want_vec_q[fetch_thr_o] |-> fetch_addr_o == VEC_BASE + ADDR_W'(VEC_STRIDE) * ADDR_W'(fetch_thr_o))
        else $error("vector fetch wrong");

    p_stall_needs_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> irq_i[fetch_thr_o])
        else $error("stall without request");

    p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_en_i[fetch_thr_o] |-> !stall_o)
        else $error("disabled interrupt taken");

    p_jump_ret_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_o && jmp_i) |-> ret_addr_o == jmp_tgt_i)
        else $error("return address is not jump target");

    p_skip_ret_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_o && skip_i && !jmp_i) |-> ret_addr_o == fetch_addr_o + ADDR_W'(2))
        else $error("return address after skip wrong");

endmodule

bind pcr_ring pcr_ring_chk #(
    .NTHR       (NTHR),
    .ADDR_W     (ADDR_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_i        (irq_i),
    .irq_en_i     (irq_en_i),
    .jmp_i        (jmp_i),
    .jmp_tgt_i    (jmp_tgt_i),
    .skip_i       (skip_i),
    .fetch_addr_o (fetch_addr_o),
    .fetch_thr_o  (fetch_thr_o),
    .stall_o      (stall_o),
    .ret_addr_o   (ret_addr_o)
);

// File: tb/pcr_ring_tb.sv
// Bench for pcr_ring: behavioural model, compared on every clock.
module pcr_ring_tb;

    localparam int NTHR = 8;
    localparam int AW   = 16;
    localparam int BASE = 'h0100;
    localparam int STR  = 4;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic [NTHR-1:0] irq_i = '0;
    logic [NTHR-1:0] irq_en_i = '0;
    logic          jmp_i = 1'b0;
    logic [AW-1:0] jmp_tgt_i = '0;
    logic          skip_i = 1'b0;
    logic [AW-1:0] fetch_addr_o;
    logic [2:0]    fetch_thr_o;
    logic          stall_o;
    logic [AW-1:0] ret_addr_o;

    int compared = 0;
    int mismatched = 0;

    int    pc_m [NTHR];
    string tag_m [NTHR];
    int    slot_m;

    always #10 clk = ~clk;

    pcr_ring u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .irq_i        (irq_i),
        .irq_en_i     (irq_en_i),
        .jmp_i        (jmp_i),
        .jmp_tgt_i    (jmp_tgt_i),
        .skip_i       (skip_i),
        .fetch_addr_o (fetch_addr_o),
        .fetch_thr_o  (fetch_thr_o),
        .stall_o      (stall_o),
        .ret_addr_o   (ret_addr_o)
    );

    function automatic int vec_of(int t);
        return (BASE + STR * t) % 65536;
    endfunction

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        slot_m = 0;
        for (int t = 0; t < NTHR; t++) begin
            pc_m[t]  = vec_of(t);
            tag_m[t] = "R1";
        end
    endtask

    // Drive one slot, compare, advance model, move to next negedge
    task automatic step(bit j, int tgt, bit s, logic [NTHR-1:0] rq, logic [NTHR-1:0] en);
        int t, flow, raw;
        bit take;
        jmp_i = j; jmp_tgt_i = AW'(tgt); skip_i = s; irq_i = rq; irq_en_i = en;
        #1;
        t    = slot_m;
        raw  = j ? tgt : pc_m[t] + (s ? 2 : 1);
        flow = raw % 65536;
        take = rq[t] && en[t];
        chk("R2", int'(fetch_thr_o), t);
        chk(tag_m[t] == "R1" ? "R1" : tag_m[t], int'(fetch_addr_o), pc_m[t]); // R3 fetch of issuing PC
        chk(take ? "R7" : "R8", int'(stall_o), int'(take));
        if (take) chk(j ? "R9" : "R7", int'(ret_addr_o), flow);
        if (take) begin
            pc_m[t] = vec_of(t); tag_m[t] = "R7";
        end else begin
            pc_m[t] = flow;
            if (raw >= 65536)  tag_m[t] = "R11";
            else if (j)        tag_m[t] = "R6";
            else if (s)        tag_m[t] = "R5";
            else               tag_m[t] = "R4";
        end
        slot_m = (slot_m + 1) % NTHR;
        @(negedge clk);
    endtask

    task automatic idle_to(int thr);
        while (slot_m != thr) step(0, 0, 0, '0, '0);
    endtask

    task automatic act(int thr, bit j, int tgt, bit s, bit rq, bit en);
        idle_to(thr);
        step(j, tgt, s, NTHR'(rq) << thr, NTHR'(en) << thr);
    endtask

    initial begin
        #(20 * 200000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int keep4;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk("R1", int'(fetch_thr_o), 0);
        chk("R1", int'(fetch_addr_o), vec_of(0));
        rst_ni = 1'b1;

        // R1 first lap, then R4 sequential steps
        repeat (24) step(0, 0, 0, '0, '0);
        // R5 skip on thread 3, R6 jump that overrides a skip on thread 6
        act(3, 0, 0, 1, 0, 0);
        act(6, 1, 'h2345, 1, 0, 0);
        // R10: jump on thread 3 leaves thread 4 intact
        keep4 = pc_m[4];
        act(3, 1, 'h0777, 0, 0, 0);
        idle_to(4);
        chk("R10", int'(fetch_addr_o), keep4);
        // R7 interrupt on thread 5
        act(5, 0, 0, 0, 1, 1);
        // R8 request without enable, and enabled request on another thread
        act(2, 0, 0, 0, 1, 0);
        idle_to(4);
        step(0, 0, 0, 8'b0010_0000, 8'b0010_0000);
        // R9 jump together with interrupt, then skip together with interrupt
        act(1, 1, 'hBEEF, 0, 1, 1);
        act(7, 0, 0, 1, 1, 1);
        // R11 wrap: jump to 0xFFFF, step; jump to 0xFFFF, skip
        act(2, 1, 'hFFFF, 0, 0, 0);
        act(2, 0, 0, 0, 0, 0);
        act(0, 1, 'hFFFF, 0, 0, 0);
        act(0, 0, 0, 1, 0, 0);
        repeat (16) step(0, 0, 0, '0, '0);

        // Random mix of flow and interrupts, all fields drawn independently
        for (int i = 0; i < 3000; i++) begin
            logic [NTHR-1:0] rq, en;
            rq = NTHR'($urandom) & NTHR'($urandom) & NTHR'($urandom);
            en = NTHR'($urandom);
            step(($urandom % 4) == 0, int'($urandom % 65536), ($urandom % 3) == 0, rq, en);
        end

        // Reset again mid-run: R1
        rst_ni = 1'b0;
        @(negedge clk);
        model_reset();
        rst_ni = 1'b1;
        repeat (10) step(0, 0, 0, '0, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule